// File: doc/BRIEF.md
# Multiplexed Bidirectional Bus Latch

This block sits between one narrow bus (the A side) and two banks of the same width (bank 1 and bank 2). It carries data both ways. Going outward, A data can be loaded into either bank or both. Each bank has its own latch and its own active-low output enable, so the block can spread a single stream across two banks. Going inward, each bank has its own capture latch, and a bank-select input picks which captured bank drives the A side. A-side output is controlled by one active-low enable.

Each port is split into an input vector, an output vector and a per-bit output-enable vector. The surrounding logic or the bench resolves these into a tri-state bus. The latches are modelled for a synchronous flow. While its enable is high, a latch passes its input straight through in the same cycle. It also records that input at every rising clock edge. While its enable is low, it presents the last value it recorded. A disabled port drives all-zero enables, and with the default parking option its data output is also zero.

Top module: `mbl_mux_latch`

## Requirements
- R1: The ports are three data ports of W bits (W=12 by default): A, bank 1 and bank 2. Each data port has an output-enable vector that is either all ones (port driven) or all zeros (high impedance).
- R2: While a latch enable is high, the output fed by that latch equals the latch input in the same cycle, with no clock edge in between.
- R3: While a latch enable is low, the latch output holds the input value sampled at the last rising clock edge at which that enable was high. This value persists across cycles, across input changes, and across periods in which the port is disabled.
- R4: With bank_sel=1 the A output comes from the bank-1 return latch (enable ret1_le). With bank_sel=0 it comes from the bank-2 return latch (enable ret2_le).
- R5: With a_en_n=1, a_oe is all zeros. With a_en_n=0, a_oe is all ones.
- R6: The forward latches load A data independently: fwd1_le loads bank 1 only, and fwd2_le loads bank 2 only.
- R7: The bank enables b1_en_n and b2_en_n are active low and independent. A bank whose enable is 1 has its oe vector all zeros, while the other bank keeps driving.
- R8: rst_n=0 asynchronously clears all four latches to zero, without waiting for a clock edge.
- R9: With PARK_ZERO (the default), a disabled port's data output reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at which latch values are recorded |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | W | A-side data arriving at the block |
| a_out | output | W | A-side data driven by the block |
| a_oe | output | W | A-side per-bit output enable |
| b1_in | input | W | Bank-1 data arriving at the block |
| b1_out | output | W | Bank-1 data driven by the block |
| b1_oe | output | W | Bank-1 per-bit output enable |
| b2_in | input | W | Bank-2 data arriving at the block |
| b2_out | output | W | Bank-2 data driven by the block |
| b2_oe | output | W | Bank-2 per-bit output enable |
| bank_sel | input | 1 | 1 selects bank-1 return latch for A, 0 selects bank 2 |
| a_en_n | input | 1 | Active-low A output enable |
| b1_en_n | input | 1 | Active-low bank-1 output enable |
| b2_en_n | input | 1 | Active-low bank-2 output enable |
| fwd1_le | input | 1 | Enable of A-to-bank-1 latch |
| fwd2_le | input | 1 | Enable of A-to-bank-2 latch |
| ret1_le | input | 1 | Enable of bank-1-to-A latch |
| ret2_le | input | 1 | Enable of bank-2-to-A latch |

## Verification
Each latch is driven with distinct non-repeating words while its enable is high. The A input is then changed with the enable low, so a latch that is still transparent cannot be mistaken for one that holds. Banks are loaded one at a time and then together, which separates independent loading from a shared enable. The select input is toggled both while the other bank's latch is still at its reset value and after it has been loaded, which exposes a swapped or stuck multiplexer. Output enables are switched singly between loads to show that disabling one port neither disturbs the other port nor loses held data, and an asynchronous reset in the middle of the run shows that the stored values clear at once.

// File: rtl/mbl_pkg.sv
package mbl_pkg;
   typedef enum logic {
      PARK_HOLD = 1'b0,
      PARK_ZERO = 1'b1
   } park_e;

   localparam int unsigned MBL_DEF_W = 12;
endpackage

// File: rtl/mbl_latch.sv
module mbl_latch #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         le,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] held;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  held <= '0;
      else if (le) held <= d;
   end

   // transparent while enabled, recorded value otherwise
   assign q = le ? d : held;
endmodule

// File: rtl/mbl_driver.sv
module mbl_driver
   import mbl_pkg::*;
#(
   parameter int unsigned W    = 12,
   parameter park_e       PARK = PARK_ZERO
) (
   input  logic         en_n,
   input  logic [W-1:0] val,
   output logic [W-1:0] out,
   output logic [W-1:0] oe
);
   assign oe = {W{~en_n}};

   generate
      if (PARK == PARK_ZERO) begin : g_park_zero
         assign out = en_n ? '0 : val;
      end else begin : g_park_hold
         assign out = val;
      end
   endgenerate
endmodule

// File: rtl/mbl_selector.sv
module mbl_selector #(
   parameter int unsigned W = 12
) (
   input  logic         sel,
   input  logic [W-1:0] from1,
   input  logic [W-1:0] from2,
   output logic [W-1:0] y
);
   assign y = sel ? from1 : from2;
endmodule

// File: rtl/mbl_mux_latch.sv
module mbl_mux_latch
   import mbl_pkg::*;
#(
   parameter int unsigned W    = MBL_DEF_W,
   parameter park_e       PARK = PARK_ZERO
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] a_in,
   output logic [W-1:0] a_out,
   output logic [W-1:0] a_oe,
   input  logic [W-1:0] b1_in,
   output logic [W-1:0] b1_out,
   output logic [W-1:0] b1_oe,
   input  logic [W-1:0] b2_in,
   output logic [W-1:0] b2_out,
   output logic [W-1:0] b2_oe,
   input  logic         bank_sel,
   input  logic         a_en_n,
   input  logic         b1_en_n,
   input  logic         b2_en_n,
   input  logic         fwd1_le,
   input  logic         fwd2_le,
   input  logic         ret1_le,
   input  logic         ret2_le
);
   localparam int unsigned NBANK = 2;

   if (W < 1) begin : g_bad_w
      $error("mbl_mux_latch: W must be at least 1");
   end

   logic [W-1:0] bank_in  [NBANK];
   logic [W-1:0] bank_out [NBANK];
   logic [W-1:0] bank_oe  [NBANK];
   logic [W-1:0] fwd_q    [NBANK];
   logic [W-1:0] ret_q    [NBANK];
   logic [NBANK-1:0] fwd_le, ret_le, bank_en_n;
   logic [W-1:0] a_val;

   assign bank_in[0] = b1_in;
   assign bank_in[1] = b2_in;
   assign fwd_le     = {fwd2_le, fwd1_le};
   assign ret_le     = {ret2_le, ret1_le};
   assign bank_en_n  = {b2_en_n, b1_en_n};

   genvar g;
   generate
      for (g = 0; g < NBANK; g++) begin : g_bank
         mbl_latch #(.W(W)) u_fwd (
            .clk(clk), .rst_n(rst_n), .le(fwd_le[g]), .d(a_in), .q(fwd_q[g])
         );
         mbl_latch #(.W(W)) u_ret (
            .clk(clk), .rst_n(rst_n), .le(ret_le[g]), .d(bank_in[g]), .q(ret_q[g])
         );
         mbl_driver #(.W(W), .PARK(PARK)) u_drv (
            .en_n(bank_en_n[g]), .val(fwd_q[g]), .out(bank_out[g]), .oe(bank_oe[g])
         );
      end
   endgenerate

   mbl_selector #(.W(W)) u_sel (
      .sel(bank_sel), .from1(ret_q[0]), .from2(ret_q[1]), .y(a_val)
   );

   mbl_driver #(.W(W), .PARK(PARK)) u_adrv (
      .en_n(a_en_n), .val(a_val), .out(a_out), .oe(a_oe)
   );

   assign b1_out = bank_out[0];
   assign b1_oe  = bank_oe[0];
   assign b2_out = bank_out[1];
   assign b2_oe  = bank_oe[1];
endmodule

// File: rtl/mbl_checker.sv
module mbl_checker #(
   parameter int unsigned W = 12
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] a_in,
   input logic [W-1:0] a_out,
   input logic [W-1:0] a_oe,
   input logic [W-1:0] b1_in,
   input logic [W-1:0] b1_out,
   input logic [W-1:0] b1_oe,
   input logic [W-1:0] b2_in,
   input logic [W-1:0] b2_out,
   input logic [W-1:0] b2_oe,
   input logic         bank_sel,
   input logic         a_en_n,
   input logic         b1_en_n,
   input logic         b2_en_n,
   input logic         fwd1_le,
   input logic         fwd2_le,
   input logic         ret1_le,
   input logic         ret2_le
);
   p_oe_whole_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (a_oe == '0 || a_oe == '1) && (b1_oe == '0 || b1_oe == '1));

   p_fwd1_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd1_le && !b1_en_n) |-> b1_out == a_in);

   p_fwd2_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!fwd2_le && !$past(fwd2_le) && !b2_en_n && !$past(b2_en_n)) |-> $stable(b2_out));

   p_sel_bank1_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_sel && ret1_le && !a_en_n) |-> a_out == b1_in);

   p_sel_bank2_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!bank_sel && ret2_le && !a_en_n) |-> a_out == b2_in);

   p_a_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
      a_en_n |-> a_oe == '0);

   p_bank2_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
      b2_en_n |-> b2_oe == '0);

   p_reset_clear_r8: assert property (@(posedge clk)
      (!rst_n && !fwd1_le && !b1_en_n) |-> b1_out == '0);

   p_park_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      b1_en_n |-> b1_out == '0);
endmodule

bind mbl_mux_latch mbl_checker #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
   .b1_in(b1_in), .b1_out(b1_out), .b1_oe(b1_oe),
   .b2_in(b2_in), .b2_out(b2_out), .b2_oe(b2_oe),
   .bank_sel(bank_sel), .a_en_n(a_en_n), .b1_en_n(b1_en_n), .b2_en_n(b2_en_n),
   .fwd1_le(fwd1_le), .fwd2_le(fwd2_le), .ret1_le(ret1_le), .ret2_le(ret2_le)
);

// File: tb/tb_mbl_mux_latch.sv
module tb_mbl_mux_latch;
   localparam int W = 12;
   localparam time CLK_PERIOD = 10;
   localparam logic [W-1:0] ON  = '1;
   localparam logic [W-1:0] OFF = '0;

   logic clk = 1'b0;
   logic rst_n;
   logic [W-1:0] a_in, b1_in, b2_in;
   logic [W-1:0] a_out, a_oe, b1_out, b1_oe, b2_out, b2_oe;
   logic bank_sel, a_en_n, b1_en_n, b2_en_n, fwd1_le, fwd2_le, ret1_le, ret2_le;

   typedef struct {
      string        tag;
      logic [W-1:0] a, aoe, b1, b1oe, b2, b2oe;
   } exp_t;

   exp_t q_exp[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   mbl_mux_latch #(.W(W)) dut (.*);

   task automatic push(string tag, logic [W-1:0] a, logic [W-1:0] aoe,
                       logic [W-1:0] b1, logic [W-1:0] b1oe,
                       logic [W-1:0] b2, logic [W-1:0] b2oe);
      exp_t e;
      e.tag = tag; e.a = a; e.aoe = aoe; e.b1 = b1; e.b1oe = b1oe;
      e.b2 = b2; e.b2oe = b2oe;
      q_exp.push_back(e);
   endtask

   task automatic cmp(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // monitor: compare once per cycle, after the driver has settled
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (q_exp.size() > 0) begin
            exp_t e;
            e = q_exp.pop_front();
            cmp(e.tag, "a_out",  a_out,  e.a);
            cmp(e.tag, "a_oe",   a_oe,   e.aoe);
            cmp(e.tag, "b1_out", b1_out, e.b1);
            cmp(e.tag, "b1_oe",  b1_oe,  e.b1oe);
            cmp(e.tag, "b2_out", b2_out, e.b2);
            cmp(e.tag, "b2_oe",  b2_oe,  e.b2oe);
         end
      end
   end

   initial begin
      for (int i = 0; i < 2000; i++) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; a_in = '0; b1_in = '0; b2_in = '0; bank_sel = 1'b1;
      a_en_n = 1'b0; b1_en_n = 1'b0; b2_en_n = 1'b0;
      fwd1_le = 0; fwd2_le = 0; ret1_le = 0; ret2_le = 0;

      @(negedge clk); push("R8 reset", OFF, ON, OFF, ON, OFF, ON);
      @(negedge clk); rst_n = 1'b1;
      push("R8 after release", OFF, ON, OFF, ON, OFF, ON);

      // A to banks
      @(negedge clk); a_en_n = 1; fwd1_le = 1; a_in = 12'hABC;
      push("R2 R6 R5 bank1 transparent", OFF, OFF, 12'hABC, ON, OFF, ON);
      @(negedge clk); fwd1_le = 0; a_in = 12'h123;
      push("R3 bank1 hold", OFF, OFF, 12'hABC, ON, OFF, ON);
      @(negedge clk); fwd2_le = 1; a_in = 12'h456;
      push("R6 bank2 only", OFF, OFF, 12'hABC, ON, 12'h456, ON);
      @(negedge clk); fwd2_le = 0; a_in = 12'h789; b1_en_n = 1;
      push("R7 R9 bank1 off", OFF, OFF, OFF, OFF, 12'h456, ON);
      @(negedge clk); b1_en_n = 0; b2_en_n = 1;
      push("R7 R3 bank2 off bank1 kept", OFF, OFF, 12'hABC, ON, OFF, OFF);
      @(negedge clk); b2_en_n = 0; fwd1_le = 1; fwd2_le = 1; a_in = 12'h5A5;
      push("R6 both loaded", OFF, OFF, 12'h5A5, ON, 12'h5A5, ON);
      @(negedge clk); fwd1_le = 0; fwd2_le = 0; a_in = 12'h000;
      push("R3 both hold", OFF, OFF, 12'h5A5, ON, 12'h5A5, ON);

      // banks to A
      @(negedge clk); b1_en_n = 1; b2_en_n = 1; a_en_n = 0;
      ret1_le = 1; b1_in = 12'h111; b2_in = 12'h222; bank_sel = 1;
      push("R2 R4 sel bank1", 12'h111, ON, OFF, OFF, OFF, OFF);
      @(negedge clk); ret1_le = 0; b1_in = 12'h333;
      push("R3 ret1 hold", 12'h111, ON, OFF, OFF, OFF, OFF);
      @(negedge clk); bank_sel = 0;
      push("R4 sel bank2 unloaded", OFF, ON, OFF, OFF, OFF, OFF);
      @(negedge clk); ret2_le = 1; b2_in = 12'h444;
      push("R2 R4 ret2 transparent", 12'h444, ON, OFF, OFF, OFF, OFF);
      @(negedge clk); ret2_le = 0; b2_in = 12'h555;
      push("R3 ret2 hold", 12'h444, ON, OFF, OFF, OFF, OFF);
      @(negedge clk); bank_sel = 1;
      push("R4 back to bank1", 12'h111, ON, OFF, OFF, OFF, OFF);
      @(negedge clk); a_en_n = 1;
      push("R5 R9 A off", OFF, OFF, OFF, OFF, OFF, OFF);
      @(negedge clk); a_en_n = 0; bank_sel = 0;
      push("R5 R3 A on again", 12'h444, ON, OFF, OFF, OFF, OFF);

      // asynchronous reset in mid run
      @(negedge clk); rst_n = 0; b1_en_n = 0; b2_en_n = 0;
      push("R8 async clear", OFF, ON, OFF, ON, OFF, ON);
      @(negedge clk); rst_n = 1; bank_sel = 1;
      push("R8 cleared bank1 return", OFF, ON, OFF, ON, OFF, ON);

      @(negedge clk); @(negedge clk); @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule